// File: doc/BRIEF.md
# Decoder Error Statistics Scanner

This block sums up the per-sector error counts that an error-correcting decoder leaves behind after a page read. The decoder's counts sit in a small bank of 32-bit words. Each word holds four sector fields, and the bank is written through a plain word-wide write port. A start pulse carries the number of sectors to examine. The block then steps through the sectors at one per clock and presents three results: the total number of corrected bits, the number of sectors that could not be corrected, and the largest bitflip count seen in any single correctable sector.

A field whose bits are all ones marks a sector that the decoder gave up on. Such a sector adds to the failure count only. It is left out of both the corrected sum and the maximum. The field width and the distance between fields are parameters. Supported pairs are a spacing of 8 with a width of 5, 6 or 7, and a spacing of 5 with a width of 5.

Top module: `ecc_err_scan`

## Requirements
- R1: After reset, busy and done are low and all three results are zero.
- R2: Sector i is read from bank word i/4, at bits starting at (i mod 4) times FIELD_SPACING, FIELD_W bits wide. Bits outside the fields have no effect. A bank write stores bank_wdata into word bank_sel.
- R3: A field equal to all ones (2^FIELD_W − 1) adds one to fail_total and changes neither corr_total nor max_flips. max_flips therefore never equals the all-ones value.
- R4: Every other field value is added to corr_total, and max_flips becomes the largest such value in the scan.
- R5: A start that is accepted clears all three results before the first sector is counted, so nothing carries over from an earlier scan.
- R6: For a count N in 1..16, busy is high for exactly N cycles, starting the cycle after start. done is high for the single cycle after the last busy cycle, and the results are final in that cycle.
- R7: A start with a count of zero raises done in the next cycle without any busy cycle, and all results are zero.
- R8: A start that arrives while busy is high is ignored. The running scan finishes with its own count and its own results.
- R9: A requested count above 16 is treated as 16.
- R10: Once done has pulsed, the results stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_wr | input | 1 | Write strobe for the count bank |
| bank_sel | input | 2 | Word index for the bank write |
| bank_wdata | input | 32 | Word written into the bank |
| start | input | 1 | Begin a scan; ignored while busy |
| sector_cnt | input | 5 | Number of sectors to scan (0..16, larger values clamp) |
| busy | output | 1 | High while sectors are being walked |
| done | output | 1 | One-cycle pulse when the results are final |
| corr_total | output | 11 | Sum of corrected bit counts |
| fail_total | output | 5 | Number of uncorrectable sectors |
| max_flips | output | 6 | Largest per-sector corrected count |

## Verification
The hardest case to reach is an uncorrectable field that sits next to, or above, the largest correctable value. In that case a design that lets the all-ones value into the maximum, or into the sum, gives a plausible but wrong answer. Random fields are drawn with a heavy bias toward all ones, and directed bank patterns add three more cases: every sector failed, the maximum placed in the last sector only, and junk in the bits between fields. A second start is injected mid-scan with a different count, and the scan-length check shows that it had no effect.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    localparam int WORD_W         = 32;
    localparam int SLOTS_PER_WORD = 4;

    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_FIN  = 2'd2
    } scan_state_e;

    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/ecc_count_bank.sv
module ecc_count_bank
    import ecc_stat_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int SEL_W = clog2_min1(NUM_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [SEL_W-1:0]              sel,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NUM_WORDS*WORD_W-1:0]   bank_flat
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr && (sel == SEL_W'(w)))
                word_q <= wdata;
        end
        assign bank_flat[w*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/ecc_field_pick.sv
module ecc_field_pick
    import ecc_stat_pkg::*;
#(
    parameter int MAX_SECTORS   = 16,
    parameter int FIELD_W       = 6,
    parameter int FIELD_SPACING = 8,
    localparam int NUM_WORDS = MAX_SECTORS / SLOTS_PER_WORD,
    localparam int IDX_W     = clog2_min1(MAX_SECTORS)
) (
    input  logic [NUM_WORDS*WORD_W-1:0] bank_flat,
    input  logic [IDX_W-1:0]            sect_idx,
    output logic [FIELD_W-1:0]          field
);

    logic [FIELD_W-1:0] fields [MAX_SECTORS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
        for (genvar s = 0; s < SLOTS_PER_WORD; s++) begin : g_s
            assign fields[w*SLOTS_PER_WORD + s] =
                bank_flat[w*WORD_W + s*FIELD_SPACING +: FIELD_W];
        end
    end

    assign field = fields[sect_idx];

endmodule

// File: rtl/ecc_stat_accum.sv
module ecc_stat_accum #(
    parameter int FIELD_W = 6,
    parameter int CNT_W   = 5,
    parameter int SUM_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               en,
    input  logic [FIELD_W-1:0] field,
    output logic [SUM_W-1:0]   sum_q,
    output logic [CNT_W-1:0]   fail_q,
    output logic [FIELD_W-1:0] max_q
);

    logic uncorrectable;
    assign uncorrectable = (field == {FIELD_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum_q  <= '0;
            fail_q <= '0;
            max_q  <= '0;
        end else if (en) begin
            if (uncorrectable) begin
                fail_q <= fail_q + 1'b1;
            end else begin
                sum_q <= sum_q + SUM_W'(field);
                if (field > max_q)
                    max_q <= field;
            end
        end
    end

endmodule

// File: rtl/ecc_err_scan.sv
module ecc_err_scan
    import ecc_stat_pkg::*;
#(
    parameter int MAX_SECTORS   = 16,
    parameter int FIELD_W       = 6,
    parameter int FIELD_SPACING = 8,
    localparam int NUM_WORDS = MAX_SECTORS / SLOTS_PER_WORD,
    localparam int SEL_W     = clog2_min1(NUM_WORDS),
    localparam int IDX_W     = clog2_min1(MAX_SECTORS),
    localparam int CNT_W     = $clog2(MAX_SECTORS + 1),
    localparam int SUM_W     = FIELD_W + CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bank_wr,
    input  logic [SEL_W-1:0]   bank_sel,
    input  logic [WORD_W-1:0]  bank_wdata,
    input  logic               start,
    input  logic [CNT_W-1:0]   sector_cnt,
    output logic               busy,
    output logic               done,
    output logic [SUM_W-1:0]   corr_total,
    output logic [CNT_W-1:0]   fail_total,
    output logic [FIELD_W-1:0] max_flips
);

    scan_state_e                 state_q;
    logic [CNT_W-1:0]            idx_q;
    logic [CNT_W-1:0]            last_q;
    logic [CNT_W-1:0]            cnt_eff;
    logic [NUM_WORDS*WORD_W-1:0] bank_flat;
    logic [FIELD_W-1:0]          field;
    logic                        accept;

    assign cnt_eff = (sector_cnt > CNT_W'(MAX_SECTORS)) ? CNT_W'(MAX_SECTORS)
                                                        : sector_cnt;
    assign accept  = start && (state_q != SCAN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
        end else if (state_q == SCAN_RUN) begin
            if (idx_q == last_q)
                state_q <= SCAN_FIN;
            else
                idx_q <= idx_q + 1'b1;
        end else if (accept) begin
            idx_q   <= '0;
            last_q  <= cnt_eff - 1'b1;
            state_q <= (cnt_eff == '0) ? SCAN_FIN : SCAN_RUN;
        end else begin
            state_q <= SCAN_IDLE;
        end
    end

    assign busy = (state_q == SCAN_RUN);
    assign done = (state_q == SCAN_FIN);

    ecc_count_bank #(
        .NUM_WORDS (NUM_WORDS)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (bank_wr),
        .sel       (bank_sel),
        .wdata     (bank_wdata),
        .bank_flat (bank_flat)
    );

    ecc_field_pick #(
        .MAX_SECTORS   (MAX_SECTORS),
        .FIELD_W       (FIELD_W),
        .FIELD_SPACING (FIELD_SPACING)
    ) u_pick (
        .bank_flat (bank_flat),
        .sect_idx  (idx_q[IDX_W-1:0]),
        .field     (field)
    );

    ecc_stat_accum #(
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W),
        .SUM_W   (SUM_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .en     (busy),
        .field  (field),
        .sum_q  (corr_total),
        .fail_q (fail_total),
        .max_q  (max_flips)
    );

endmodule

// File: rtl/ecc_err_scan_chk.sv
module ecc_err_scan_chk #(
    parameter int FIELD_W = 6,
    parameter int CNT_W   = 5,
    parameter int SUM_W   = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [CNT_W-1:0]   sector_cnt,
    input logic               busy,
    input logic               done,
    input logic [SUM_W-1:0]   corr_total,
    input logic [CNT_W-1:0]   fail_total,
    input logic [FIELD_W-1:0] max_flips
);

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && sector_cnt == '0) |=> (done && !busy && corr_total == '0
                                                  && fail_total == '0 && max_flips == '0));

    // R3
    max_not_fail_chk: assert property (@(posedge clk) disable iff (rst)
        max_flips != {FIELD_W{1'b1}});

    // R4
    sum_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (corr_total >= $past(corr_total)) && (fail_total >= $past(fail_total)));

    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(corr_total) && $stable(fail_total) && $stable(max_flips)));

endmodule

bind ecc_err_scan ecc_err_scan_chk #(
    .FIELD_W (FIELD_W),
    .CNT_W   (CNT_W),
    .SUM_W   (SUM_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sector_cnt (sector_cnt),
    .busy       (busy),
    .done       (done),
    .corr_total (corr_total),
    .fail_total (fail_total),
    .max_flips  (max_flips)
);

// File: tb/ecc_err_scan_test.sv
`timescale 1ns/1ps
module ecc_err_scan_test;

    localparam int FW    = 6;
    localparam int SP    = 8;
    localparam int MAXS  = 16;
    localparam int CW    = 5;
    localparam int SW    = 11;
    localparam logic [FW-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bank_wr = 1'b0;
    logic [1:0]    bank_sel = '0;
    logic [31:0]   bank_wdata = '0;
    logic          start = 1'b0;
    logic [CW-1:0] sector_cnt = '0;
    logic          busy, done;
    logic [SW-1:0] corr_total;
    logic [CW-1:0] fail_total;
    logic [FW-1:0] max_flips;

    int checks = 0;
    int failures = 0;
    logic [FW-1:0] fld [MAXS];

    always #2.5 clk = ~clk;

    ecc_err_scan uut (
        .clk(clk), .rst(rst), .bank_wr(bank_wr), .bank_sel(bank_sel),
        .bank_wdata(bank_wdata), .start(start), .sector_cnt(sector_cnt),
        .busy(busy), .done(done), .corr_total(corr_total),
        .fail_total(fail_total), .max_flips(max_flips)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pack bench fields into words, junk in the gaps (R2)
    task automatic load_bank();
        for (int w = 0; w < 4; w++) begin
            logic [31:0] word;
            word = $urandom;
            for (int s = 0; s < 4; s++)
                word[s*SP +: FW] = fld[w*4+s];
            @(negedge clk);
            bank_wr = 1'b1; bank_sel = 2'(w); bank_wdata = word;
        end
        @(negedge clk);
        bank_wr = 1'b0;
    endtask

    function automatic int exp_sum(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) if (fld[i] != ALL1) s += int'(fld[i]);
        return s;
    endfunction
    function automatic int exp_fail(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) if (fld[i] == ALL1) s++;
        return s;
    endfunction
    function automatic int exp_max(input int n);
        int m = 0;
        for (int i = 0; i < n; i++)
            if (fld[i] != ALL1 && int'(fld[i]) > m) m = int'(fld[i]);
        return m;
    endfunction

    task automatic run_scan(input int req_n, input bit inject, input string tag);
        int n, cyc, guard;
        n = (req_n > MAXS) ? MAXS : req_n;
        @(negedge clk);
        start = 1'b1; sector_cnt = CW'(req_n);
        @(negedge clk);
        start = 1'b0; sector_cnt = '0;
        cyc = 0; guard = 0;
        while (!done && guard < 40) begin
            if (busy) cyc++;
            if (inject && cyc == 2) begin
                start = 1'b1; sector_cnt = CW'(3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk({tag, " R6 busy cycles"}, cyc, n);
        chk({tag, " R6 done seen"}, int'(done), 1);
        chk({tag, " R4 corr_total"}, int'(corr_total), exp_sum(n));
        chk({tag, " R3 fail_total"}, int'(fail_total), exp_fail(n));
        chk({tag, " R4 max_flips"}, int'(max_flips), exp_max(n));
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, int'(done), 0);
        repeat (3) @(negedge clk);
        // R10 held after done
        chk({tag, " R10 hold sum"}, int'(corr_total), exp_sum(n));
        chk({tag, " R10 hold fail"}, int'(fail_total), exp_fail(n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 sum", int'(corr_total), 0);
        chk("R1 fail", int'(fail_total), 0);
        chk("R1 max", int'(max_flips), 0);

        // R2 R4 all zero then ramp
        for (int i = 0; i < MAXS; i++) fld[i] = '0;
        load_bank();
        run_scan(16, 1'b0, "zeros");
        for (int i = 0; i < MAXS; i++) fld[i] = FW'(i + 1);
        load_bank();
        run_scan(16, 1'b0, "ramp R2");

        // R3 every sector failed; R5 results of prior scan cleared
        for (int i = 0; i < MAXS; i++) fld[i] = ALL1;
        load_bank();
        run_scan(9, 1'b0, "allfail R5");

        // R3 max only in last sector, neighbours failed
        for (int i = 0; i < MAXS; i++) fld[i] = (i % 2 == 0) ? ALL1 : FW'(3);
        fld[15] = ALL1 - 1'b1;
        load_bank();
        run_scan(16, 1'b0, "lastmax R3");

        // R7 zero count, after a nonzero scan
        @(negedge clk);
        start = 1'b1; sector_cnt = '0;
        @(negedge clk);
        start = 1'b0;
        chk("R7 done", int'(done), 1);
        chk("R7 busy", int'(busy), 0);
        chk("R7 sum", int'(corr_total), 0);
        chk("R7 fail", int'(fail_total), 0);
        chk("R7 max", int'(max_flips), 0);
        @(negedge clk);

        // R9 clamp, R8 injected start while busy
        for (int i = 0; i < MAXS; i++) fld[i] = FW'($urandom);
        load_bank();
        run_scan(20, 1'b0, "clamp R9");
        run_scan(11, 1'b1, "inject R8");

        // random
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < MAXS; i++)
                fld[i] = ($urandom % 4 == 0) ? ALL1 : FW'($urandom);
            load_bank();
            run_scan(int'($urandom % 17), ($urandom % 4) == 0, "rand R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule